// File: doc/BRIEF.md
# Byte-to-Word ATA Task-File Bridge

This block sits between an 8-bit host I/O bus and the 16-bit register interface of an ATA/IDE drive. It claims a 16-byte window of I/O space whose upper address bits are fixed high and whose next two bits follow a slot or chain position input. Inside the window, the first twelve offsets pair up onto the six word-wide task-file registers. The remaining offsets reach the byte-wide device, control/alternate-status and command/status registers. The last offset is a dead slot.

Each word-wide register is reached through two byte accesses with a fixed order. For a read, the even (low) offset runs the real 16-bit ATA read, returns bits 7:0 and keeps bits 15:8 in a read latch. A following odd-offset read then returns that latch with no bus cycle. For a write, the odd (high) offset fills a holding latch. The even offset then sends the whole word out in one ATA write. The host issues a one-cycle request and waits for a one-cycle acknowledge. For accesses that reach the drive, the acknowledge follows a setup cycle, a strobe of configurable length and a hold cycle.

Top module: `ata_byte_bridge`

## Requirements
- R1: An access is claimed only when host_addr[7:4] equals {2'b11, slot_sel}. Any other address gives no acknowledge, no chip select, no strobe and no host data drive, and the slot input moves the window.
- R2: For offsets 0x0..0xB the drive address is offset[3:1] with command-block select (ata_cs0_n low, ata_cs1_n high). For 0xC the address is 6 and for 0xE it is 7, both on the command block. 0xD uses address 6 on the control block (ata_cs1_n low, ata_cs0_n high).
- R3: A read at an even offset below 0xC runs one ATA read and returns the drive's bits 7:0 on host_rdata. It also stores the drive's bits 15:8 in the read latch.
- R4: A read at an odd offset below 0xC returns the read latch with no ATA cycle, and is acknowledged in the first cycle after the request.
- R5: A write at an odd offset below 0xC only loads the write holding latch with host_wdata. It starts no ATA cycle and is acknowledged in the first cycle after the request.
- R6: A write at an even offset below 0xC runs one ATA write that drives {holding latch, host_wdata} on ata_dd_o.
- R7: Offsets 0xC..0xE move a single byte. Reads return the drive's bits 7:0, and writes drive {8'h00, host_wdata}.
- R8: Offset 0xF reads as UNDEF_VAL (default 8'hFF). A write there starts no ATA cycle. Both are acknowledged in the first cycle after the request.
- R9: An ATA cycle holds address and select for one cycle, then keeps the strobe low for STROBE_CYC cycles, then holds address and select for one more cycle. The acknowledge comes in the next cycle, STROBE_CYC+3 cycles after the request.
- R10: ata_dd_oe is high only from the setup to the hold cycle of an ATA write, and low at all other times.
- R11: Reads of 0xC..0xF leave the read latch unchanged. Reset clears the write holding latch to 8'h00.
- R12: host_ack is high for exactly one cycle per claimed access. host_rdata_oe is high only in that cycle, and only for reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slot_sel | input | 2 | Slot/chain position choosing the window base |
| host_req | input | 1 | One-cycle access request |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_addr | input | 8 | Host I/O address |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Host read byte, valid while host_rdata_oe |
| host_rdata_oe | output | 1 | Bridge drives the host data bus |
| host_ack | output | 1 | One-cycle completion |
| ata_da | output | 3 | ATA register address |
| ata_cs0_n | output | 1 | Command-block select, active low |
| ata_cs1_n | output | 1 | Control-block select, active low |
| ata_dior_n | output | 1 | ATA read strobe, active low |
| ata_diow_n | output | 1 | ATA write strobe, active low |
| ata_dd_o | output | 16 | ATA data out |
| ata_dd_oe | output | 1 | ATA data output enable |
| ata_dd_i | input | 16 | ATA data in |

## Verification
A request driven before edge 0 is claimed at that edge. A local access (high-byte read, high-byte write, offset 0xF) then shows its acknowledge during cycle 1. A drive access shows select and address from cycle 1, the strobe from cycle 2 through STROBE_CYC+1, a hold cycle at STROBE_CYC+2 and the acknowledge at STROBE_CYC+3. The reference model in the bench works out those cycle numbers for each access. It compares every ATA and host output at each falling edge until one cycle past the acknowledge, which also shows that the acknowledge lasts only one cycle. Read bytes are compared only in the acknowledge cycle, and written words only while the output enable is expected.

// File: rtl/ata_bridge_pkg.sv
package ata_bridge_pkg;

   typedef enum logic [2:0] {
      SEQ_IDLE,
      SEQ_SETUP,
      SEQ_STROBE,
      SEQ_HOLD,
      SEQ_DONE
   } seq_state_t;

   typedef struct packed {
      logic       hit;      // address lands in this window
      logic       word;     // one half of a 16-bit register
      logic       upper;    // odd half (bits 15:8)
      logic       ctl_blk;  // control block select instead of command block
      logic       undef;    // dead slot
      logic [2:0] reg_addr; // ATA register address
   } win_dec_t;

   localparam logic [2:0] REG_DEVICE = 3'd6;
   localparam logic [2:0] REG_STATUS = 3'd7;

endpackage

// File: rtl/ata_bridge_decode.sv
module ata_bridge_decode
   import ata_bridge_pkg::*;
#(
   parameter int HOST_AW = 8,
   parameter int SLOT_W  = 2
) (
   input  logic [HOST_AW-1:0] addr,
   input  logic [SLOT_W-1:0]  slot,
   output win_dec_t           dec
);
   localparam int OFF_W = 4;
   localparam int TAG_W = HOST_AW - OFF_W;
   localparam int FIX_W = TAG_W - SLOT_W;
   localparam int WORD_SLOTS = 12;

   if (FIX_W < 1) begin : g_bad_width
      $error("HOST_AW too small for the slot field");
   end

   logic [TAG_W-1:0] tag;
   logic [TAG_W-1:0] base_tag;
   logic [OFF_W-1:0] off;

   assign tag      = addr[HOST_AW-1:OFF_W];
   assign base_tag = {{FIX_W{1'b1}}, slot};
   assign off      = addr[OFF_W-1:0];

   always_comb begin
      dec     = '0;
      dec.hit = (tag == base_tag);
      if (int'(off) < WORD_SLOTS) begin
         dec.word     = 1'b1;
         dec.upper    = off[0];
         dec.reg_addr = off[3:1];
      end else begin
         case (off[1:0])
            2'b00:   dec.reg_addr = REG_DEVICE;
            2'b01: begin
               dec.reg_addr = REG_DEVICE;
               dec.ctl_blk  = 1'b1;
            end
            2'b10:   dec.reg_addr = REG_STATUS;
            default: dec.undef = 1'b1;
         endcase
      end
   end

endmodule

// File: rtl/ata_bridge_latch.sv
module ata_bridge_latch #(
   parameter int BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_load,
   input  logic [BYTE_W-1:0] rd_val,
   input  logic              wr_load,
   input  logic [BYTE_W-1:0] wr_val,
   output logic [BYTE_W-1:0] rd_q,
   output logic [BYTE_W-1:0] wr_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_q <= '0;
         wr_q <= '0;
      end else begin
         if (rd_load) rd_q <= rd_val;
         if (wr_load) wr_q <= wr_val;
      end
   end

endmodule

// File: rtl/ata_bridge_seq.sv
module ata_bridge_seq
   import ata_bridge_pkg::*;
#(
   parameter int STROBE_CYC = 3
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start_ata,
   input  logic       start_local,
   output seq_state_t st,
   output logic       last_strobe
);
   localparam int CNT_W = (STROBE_CYC > 1) ? $clog2(STROBE_CYC) : 1;

   if (STROBE_CYC < 1) begin : g_bad_strobe
      $error("STROBE_CYC must be at least 1");
   end

   logic strobe_end;

   if (STROBE_CYC == 1) begin : g_single
      assign strobe_end = 1'b1;
   end else begin : g_count
      logic [CNT_W-1:0] cnt;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                cnt <= '0;
         else if (st != SEQ_STROBE) cnt <= '0;
         else if (!strobe_end)      cnt <= cnt + 1'b1;
      end
      assign strobe_end = (cnt == CNT_W'(STROBE_CYC - 1));
   end

   assign last_strobe = (st == SEQ_STROBE) && strobe_end;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st <= SEQ_IDLE;
      end else begin
         case (st)
            SEQ_IDLE: begin
               if (start_ata)        st <= SEQ_SETUP;
               else if (start_local) st <= SEQ_DONE;
            end
            SEQ_SETUP:  st <= SEQ_STROBE;
            SEQ_STROBE: if (strobe_end) st <= SEQ_HOLD;
            SEQ_HOLD:   st <= SEQ_DONE;
            default:    st <= SEQ_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/ata_byte_bridge.sv
module ata_byte_bridge
   import ata_bridge_pkg::*;
#(
   parameter int         STROBE_CYC = 3,
   parameter logic [7:0] UNDEF_VAL  = 8'hFF
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic [1:0]  slot_sel,
   input  logic        host_req,
   input  logic        host_wr,
   input  logic [7:0]  host_addr,
   input  logic [7:0]  host_wdata,
   output logic [7:0]  host_rdata,
   output logic        host_rdata_oe,
   output logic        host_ack,
   output logic [2:0]  ata_da,
   output logic        ata_cs0_n,
   output logic        ata_cs1_n,
   output logic        ata_dior_n,
   output logic        ata_diow_n,
   output logic [15:0] ata_dd_o,
   output logic        ata_dd_oe,
   input  logic [15:0] ata_dd_i
);
   localparam int BYTE_W = 8;
   localparam int WORD_W = 2 * BYTE_W;

   win_dec_t            dec;
   win_dec_t            cap_dec;
   logic                cap_wr;
   logic [BYTE_W-1:0]   cap_wd;
   logic [BYTE_W-1:0]   rdata_q;
   logic [BYTE_W-1:0]   rd_q;
   logic [BYTE_W-1:0]   wr_q;
   seq_state_t          st;
   logic                last_strobe;
   logic                idle;
   logic                accept;
   logic                is_local;
   logic                bus_active;

   ata_bridge_decode #(.HOST_AW(8), .SLOT_W(2)) u_dec (
      .addr (host_addr),
      .slot (slot_sel),
      .dec  (dec)
   );

   assign idle     = (st == SEQ_IDLE);
   assign accept   = idle && host_req && dec.hit;
   assign is_local = (dec.word && dec.upper) || dec.undef;

   ata_bridge_seq #(.STROBE_CYC(STROBE_CYC)) u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .start_ata   (accept && !is_local),
      .start_local (accept && is_local),
      .st          (st),
      .last_strobe (last_strobe)
   );

   ata_bridge_latch #(.BYTE_W(BYTE_W)) u_latch (
      .clk     (clk),
      .rst_n   (rst_n),
      .rd_load (last_strobe && !cap_wr && cap_dec.word),
      .rd_val  (ata_dd_i[WORD_W-1:BYTE_W]),
      .wr_load (accept && host_wr && dec.word && dec.upper),
      .wr_val  (host_wdata),
      .rd_q    (rd_q),
      .wr_q    (wr_q)
   );

   // capture the request and produce the returned byte
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cap_dec <= '0;
         cap_wr  <= 1'b0;
         cap_wd  <= '0;
         rdata_q <= '0;
      end else begin
         if (accept) begin
            cap_dec <= dec;
            cap_wr  <= host_wr;
            cap_wd  <= host_wdata;
            if (is_local) rdata_q <= dec.undef ? UNDEF_VAL : rd_q;
         end
         if (last_strobe && !cap_wr) rdata_q <= ata_dd_i[BYTE_W-1:0];
      end
   end

   assign bus_active = (st == SEQ_SETUP) || (st == SEQ_STROBE) || (st == SEQ_HOLD);

   assign ata_da     = bus_active ? cap_dec.reg_addr : 3'd0;
   assign ata_cs0_n  = !(bus_active && !cap_dec.ctl_blk);
   assign ata_cs1_n  = !(bus_active && cap_dec.ctl_blk);
   assign ata_dior_n = !((st == SEQ_STROBE) && !cap_wr);
   assign ata_diow_n = !((st == SEQ_STROBE) && cap_wr);
   assign ata_dd_oe  = bus_active && cap_wr;
   assign ata_dd_o   = !ata_dd_oe   ? '0 :
                       cap_dec.word ? {wr_q, cap_wd} : {{BYTE_W{1'b0}}, cap_wd};

   assign host_ack      = (st == SEQ_DONE);
   assign host_rdata_oe = host_ack && !cap_wr;
   assign host_rdata    = host_rdata_oe ? rdata_q : '0;

endmodule

// File: rtl/ata_byte_bridge_chk.sv
module ata_byte_bridge_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        host_ack,
   input logic        host_rdata_oe,
   input logic [2:0]  ata_da,
   input logic        ata_cs0_n,
   input logic        ata_cs1_n,
   input logic        ata_dior_n,
   input logic        ata_diow_n,
   input logic        ata_dd_oe
);
   logic strobe;
   logic sel;
   assign strobe = !ata_dior_n || !ata_diow_n;
   assign sel    = !ata_cs0_n || !ata_cs1_n;

   AST_ONE_SELECT: assert property (@(posedge clk) disable iff (!rst_n) !(!ata_cs0_n && !ata_cs1_n)); // R2
   AST_STROBE_NEEDS_SEL: assert property (@(posedge clk) disable iff (!rst_n) strobe |-> sel); // R2
   AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(!ata_dior_n && !ata_diow_n)); // R9
   AST_SETUP_BEFORE: assert property (@(posedge clk) disable iff (!rst_n) $rose(strobe) |-> $past(sel)); // R9
   AST_HOLD_AFTER: assert property (@(posedge clk) disable iff (!rst_n) $fell(strobe) |-> sel && $stable(ata_da)); // R9
   AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n) (strobe && $past(strobe)) |-> $stable(ata_da)); // R9
   AST_OE_ONLY_WRITE: assert property (@(posedge clk) disable iff (!rst_n) ata_dd_oe |-> sel && ata_dior_n); // R10
   AST_ACK_PULSE: assert property (@(posedge clk) disable iff (!rst_n) host_ack |=> !host_ack); // R12
   AST_RDOE_IN_ACK: assert property (@(posedge clk) disable iff (!rst_n) host_rdata_oe |-> host_ack); // R12
   AST_ACK_IDLE_BUS: assert property (@(posedge clk) disable iff (!rst_n) host_ack |-> !sel && !strobe); // R9

endmodule

bind ata_byte_bridge ata_byte_bridge_chk u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .host_ack      (host_ack),
   .host_rdata_oe (host_rdata_oe),
   .ata_da        (ata_da),
   .ata_cs0_n     (ata_cs0_n),
   .ata_cs1_n     (ata_cs1_n),
   .ata_dior_n    (ata_dior_n),
   .ata_diow_n    (ata_diow_n),
   .ata_dd_oe     (ata_dd_oe)
);

// File: tb/ata_byte_bridge_tb.sv
`timescale 1ns/1ps
module ata_byte_bridge_tb;
   localparam int N = 3;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  slot_sel = 2'd2;
   logic        host_req = 1'b0;
   logic        host_wr = 1'b0;
   logic [7:0]  host_addr = 8'h00;
   logic [7:0]  host_wdata = 8'h00;
   logic [7:0]  host_rdata;
   logic        host_rdata_oe;
   logic        host_ack;
   logic [2:0]  ata_da;
   logic        ata_cs0_n, ata_cs1_n, ata_dior_n, ata_diow_n;
   logic [15:0] ata_dd_o;
   logic        ata_dd_oe;
   logic [15:0] ata_dd_i = 16'h0000;

   int checks = 0;
   int errors = 0;
   logic [7:0] m_rdl = 8'h00;  // model read latch
   logic [7:0] m_wrl = 8'h00;  // model write latch

   always #5 clk = ~clk;

   ata_byte_bridge #(.STROBE_CYC(N), .UNDEF_VAL(8'hFF)) u_dut (
      .clk(clk), .rst_n(rst_n), .slot_sel(slot_sel), .host_req(host_req),
      .host_wr(host_wr), .host_addr(host_addr), .host_wdata(host_wdata),
      .host_rdata(host_rdata), .host_rdata_oe(host_rdata_oe), .host_ack(host_ack),
      .ata_da(ata_da), .ata_cs0_n(ata_cs0_n), .ata_cs1_n(ata_cs1_n),
      .ata_dior_n(ata_dior_n), .ata_diow_n(ata_diow_n), .ata_dd_o(ata_dd_o),
      .ata_dd_oe(ata_dd_oe), .ata_dd_i(ata_dd_i)
   );

   task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
      end
   endtask

   // vector: {ack, rdata_oe, cs0_n, cs1_n, da[2:0], dior_n, diow_n, dd_oe}
   function automatic logic [9:0] outs();
      return {host_ack, host_rdata_oe, ata_cs0_n, ata_cs1_n, ata_da, ata_dior_n, ata_diow_n, ata_dd_oe};
   endfunction

   task automatic acc(input bit wr, input logic [7:0] a, input logic [7:0] wd,
                      input logic [15:0] dev, input string tag);
      logic [3:0] off;
      bit hit, word, upper, undef, ctl, isata, act, stb, ack;
      logic [2:0] da;
      logic [15:0] exp_dd;
      logic [7:0] exp_rd;
      int lat;
      off   = a[3:0];
      hit   = (a[7:4] == {2'b11, slot_sel});
      word  = (off < 4'd12);
      upper = word && off[0];
      undef = (off == 4'hF);
      ctl   = (off == 4'hD);
      da    = word ? off[3:1] : ((off == 4'hE) ? 3'd7 : 3'd6);
      isata = hit && !upper && !undef;
      lat   = !hit ? 3 : (isata ? N + 3 : 1);
      exp_dd = word ? {m_wrl, wd} : {8'h00, wd};
      exp_rd = isata ? dev[7:0] : (undef ? 8'hFF : m_rdl);
      @(negedge clk);
      ata_dd_i = dev; host_wr = wr; host_addr = a; host_wdata = wd; host_req = 1'b1;
      for (int i = 1; i <= lat + 1; i++) begin
         @(negedge clk);
         act = isata && (i <= N + 2);
         stb = isata && (i >= 2) && (i <= N + 1);
         ack = hit && (i == lat);
         chk(tag, "bus", 32'(outs()),
             32'({ack, ack && !wr, !(act && !ctl), !(act && ctl), act ? da : 3'd0,
                  !(stb && !wr), !(stb && wr), act && wr}));
         if (act && wr) chk(tag, "dd_o", 32'(ata_dd_o), 32'(exp_dd));
         if (ack && !wr) chk(tag, "rdata", 32'(host_rdata), 32'(exp_rd));
         if (i == 1) host_req = 1'b0;
      end
      if (hit && wr && upper) m_wrl = wd;
      if (isata && !wr && word) m_rdl = dev[15:8];
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // reset state: everything idle
      chk("R12", "reset", 32'(outs()), 32'(10'b00_11_000_11_0));
      rst_n = 1'b1;
      @(negedge clk);
      chk("R10", "idle", 32'(outs()), 32'(10'b00_11_000_11_0));
      // R11: holding latch cleared by reset -> upper byte 00
      acc(1'b1, 8'hE8, 8'h77, 16'h0000, "R11");
      // R3 / R4: data register read pair
      acc(1'b0, 8'hE0, 8'h00, 16'hBEEF, "R3");
      acc(1'b0, 8'hE1, 8'h00, 16'h0000, "R4");
      // R7 status read, then R11 latch untouched
      acc(1'b0, 8'hEE, 8'h00, 16'h1250, "R7");
      acc(1'b0, 8'hE1, 8'h00, 16'h0000, "R11");
      // R2 alternate status via control block, device register
      acc(1'b0, 8'hED, 8'h00, 16'h33A5, "R2");
      acc(1'b0, 8'hEC, 8'h00, 16'h44E0, "R2");
      // R2 LBA high pair
      acc(1'b0, 8'hEA, 8'h00, 16'h9C3D, "R2");
      acc(1'b0, 8'hEB, 8'h00, 16'h0000, "R4");
      // R5 / R6 write pair on sector count
      acc(1'b1, 8'hE5, 8'h12, 16'h0000, "R5");
      acc(1'b1, 8'hE4, 8'h34, 16'h0000, "R6");
      // R6 data write pair, R10 bus enable
      acc(1'b1, 8'hE1, 8'hA5, 16'h0000, "R5");
      acc(1'b1, 8'hE0, 8'h5A, 16'h0000, "R10");
      // R7 command and device-control writes
      acc(1'b1, 8'hEE, 8'hEC, 16'h0000, "R7");
      acc(1'b1, 8'hED, 8'h02, 16'h0000, "R7");
      // R8 dead slot
      acc(1'b0, 8'hEF, 8'h00, 16'h1234, "R8");
      acc(1'b1, 8'hEF, 8'h99, 16'h0000, "R8");
      // R1 window decode and slot movement
      acc(1'b0, 8'hC0, 8'h00, 16'h5555, "R1");
      acc(1'b1, 8'hF4, 8'h11, 16'h0000, "R1");
      slot_sel = 2'd0;
      acc(1'b0, 8'hC0, 8'h00, 16'h6677, "R1");
      acc(1'b0, 8'hE0, 8'h00, 16'h8888, "R1");
      slot_sel = 2'd3;
      acc(1'b0, 8'hF1, 8'h00, 16'h0000, "R12");
      acc(1'b0, 8'hF2, 8'h00, 16'hC0DE, "R9");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule